// File: doc/BRIEF.md
# TDM Pair Extractor with Stereo Re-serialiser

This block picks one stereo pair out of a four-slot, 256-bit-per-frame TDM stream coming from a multichannel ADC. It sends that pair onward as an ordinary two-channel serial stream for a digital audio transmitter. The block generates the stereo stream's word clock and bit clock itself, from the TDM bit rate. The same 3-bit route code can instead hand one of four raw ADC serial lines straight through to the transmitter. A separate clock-source bit decides whether the transmitter is timed by the generated clocks or by the ADC's own word and bit clocks. A format bit selects left-justified or I2S framing for the generated stream.

Everything runs on one clock at the TDM bit rate. One clock cycle is one TDM bit, and a one-cycle frame pulse marks bit 0. Every output is registered. The route code, clock source and format are sampled only at a frame start, so a change made in the middle of a frame can never cut a word in two.

Top module: `tdm_pair_extractor`

## Requirements
- R1: A high `tdm_fs` marks TDM bit 0 of a frame, and the frame position then advances by one per clock up to 255. Slot k (k = 0..3) covers positions 64k to 64k+63: first its 32-bit left word and then its 32-bit right word, each sent most significant bit first, on `adc_sd[1]`.
- R2: Route codes 3'b100, 3'b101, 3'b110 and 3'b111 extract slot 0, 1, 2 and 3 respectively (ADC1, ADC2, ADC3, auxiliary ADC).
- R3: A pair captured during an extracting frame is sent in the following frame. A frame that passes a line through captures nothing, and the last extracted pair stays buffered.
- R4: The generated bit clock lasts 4 TDM bits per output bit: low for the first two, high for the next two. This gives 64 output bits per frame, starting at frame position 0.
- R5: The generated word clock is low for output bits 0..31 (left) and high for output bits 32..63 (right).
- R6: With `fmt_i2s` = 0 (left-justified), output bit b carries pair bit b, counting from the left word's MSB.
- R7: With `fmt_i2s` = 1 (I2S), output bit b carries pair bit b-1. Output bit 0 carries the LSB of the right word of the pair that was buffered during the previous frame.
- R8: Route codes 3'b000, 3'b001, 3'b010 and 3'b011 pass `adc_sd[0]`, `adc_sd[2]`, `adc_sd[3]` and `adc_sd[1]` to `tx_sdata` with one clock of delay.
- R9: With `clk_ext` = 0, `tx_lrck` and `tx_sclk` repeat `adc_lrck` and `adc_sclk` one clock later. With `clk_ext` = 1 they carry the generated clocks.
- R10: `pick_sel`, `clk_ext` and `fmt_i2s` are sampled only at frame position 0. Changing them at any other position has no effect until the next frame start.
- R11: While `rst` is high, all outputs are 0. After reset the frame position is 0, the pair buffer is empty, and the active setting is route 3'b100, generated clocks, left-justified, until the first frame start.
- R12: Every output shows, one clock later, the result for the frame position of the cycle in which the inputs were sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TDM bit clock (256 cycles per audio frame) |
| rst | input | 1 | Synchronous active-high reset |
| tdm_fs | input | 1 | Frame pulse, high during TDM bit 0 |
| adc_sd | input | 4 | Raw ADC serial lines; line 1 carries the TDM stream |
| adc_lrck | input | 1 | ADC word clock, for pass-through timing |
| adc_sclk | input | 1 | ADC bit clock, for pass-through timing |
| pick_sel | input | 3 | Route code: line pass-through or slot extraction |
| clk_ext | input | 1 | 1 = generated clocks, 0 = ADC clocks to transmitter |
| fmt_i2s | input | 1 | 1 = I2S framing, 0 = left-justified |
| tx_sdata | output | 1 | Serial data to transmitter |
| tx_lrck | output | 1 | Word clock to transmitter |
| tx_sclk | output | 1 | Bit clock to transmitter |

## Verification
Clock and pass-through results are due one clock after the inputs that cause them. An extracted pair appears one frame plus one clock after the slot that carried it. A route change takes effect at the next frame start. The bench drives inputs on the falling edge for each frame position. It compares the outputs on the next falling edge against a model that holds the setting latched at position 0 and the pair captured in the previous frame. The model therefore never needs to guess which register stage a value is in.

// File: rtl/tdm_x_pkg.sv
package tdm_x_pkg;

    localparam int ADC_LINES = 4;
    localparam int TDM_LINE  = 1;

    typedef struct packed {
        logic [2:0] pick;
        logic       ext_clk;
        logic       i2s;
    } route_cfg_t;

    localparam route_cfg_t CFG_RESET = '{pick: 3'b100, ext_clk: 1'b1, i2s: 1'b0};

    function automatic logic pick_is_slot(input logic [2:0] pick);
        return pick[2];
    endfunction

    function automatic logic [1:0] pick_line(input logic [2:0] pick);
        case (pick[1:0])
            2'd0:    return 2'd0;
            2'd1:    return 2'd2;
            2'd2:    return 2'd3;
            default: return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker
    import tdm_x_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    localparam int POS_W = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fs,
    input  route_cfg_t       cfg_in,
    output logic [POS_W-1:0] pos,
    output route_cfg_t       cfg_eff,
    output logic             frame_last
);

    logic [POS_W-1:0] cnt_q;
    route_cfg_t       cfg_q;

    always_comb begin
        if (fs)
            pos = '0;
        else if (cnt_q == POS_W'(FRAME_BITS - 1))
            pos = '0;
        else
            pos = cnt_q + 1'b1;
    end

    assign frame_last = (pos == POS_W'(FRAME_BITS - 1));
    assign cfg_eff    = (pos == '0) ? cfg_in : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cfg_q <= CFG_RESET;
        end else begin
            cnt_q <= pos;
            cfg_q <= cfg_eff;
        end
    end

    // R1
    fs_align_chk: assert property (@(posedge clk) disable iff (rst)
        fs |=> (cnt_q == '0));

    // R1
    pos_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!fs && cnt_q != POS_W'(FRAME_BITS - 1)) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R10
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pos != '0) |=> (cfg_q == $past(cfg_q)));

endmodule

// File: rtl/tdm_pair_capture.sv
module tdm_pair_capture #(
    parameter int FRAME_BITS = 256,
    parameter int SLOTS      = 4,
    parameter int WORD_BITS  = 32,
    localparam int POS_W     = $clog2(FRAME_BITS),
    localparam int SLOT_W    = $clog2(SLOTS),
    localparam int PAIR_BITS = 2 * WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 din,
    input  logic [POS_W-1:0]     pos,
    input  logic [SLOT_W-1:0]    slot,
    input  logic                 enable,
    input  logic                 frame_last,
    output logic [PAIR_BITS-1:0] pair,
    output logic                 prev_lsb
);

    localparam int SLOT_LEN = FRAME_BITS / SLOTS;

    logic [SLOT_W-1:0]    cur_slot;
    logic                 in_slot;
    logic [PAIR_BITS-1:0] shift_q, shift_next, hold_q;
    logic                 prev_q;

    assign cur_slot   = SLOT_W'(pos / POS_W'(SLOT_LEN));
    assign in_slot    = enable && (cur_slot == slot);
    assign shift_next = in_slot ? {shift_q[PAIR_BITS-2:0], din} : shift_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            hold_q  <= '0;
            prev_q  <= 1'b0;
        end else begin
            shift_q <= shift_next;
            if (frame_last) begin
                prev_q <= hold_q[0];
                if (enable)
                    hold_q <= shift_next;
            end
        end
    end

    assign pair     = hold_q;
    assign prev_lsb = prev_q;

    // R3
    hold_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(hold_q));

    // R7
    prev_frame_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_last |=> $stable(prev_q));

endmodule

// File: rtl/stereo_serializer.sv
module stereo_serializer #(
    parameter int FRAME_BITS = 256,
    parameter int WORD_BITS  = 32,
    localparam int POS_W     = $clog2(FRAME_BITS),
    localparam int PAIR_BITS = 2 * WORD_BITS,
    localparam int BIT_W     = $clog2(PAIR_BITS),
    localparam int DIV       = FRAME_BITS / PAIR_BITS,
    localparam int SUB_W     = $clog2(DIV)
) (
    input  logic [POS_W-1:0]     pos,
    input  logic [PAIR_BITS-1:0] pair,
    input  logic                 prev_lsb,
    input  logic                 i2s,
    output logic                 sdata,
    output logic                 lrck,
    output logic                 sclk
);

    logic [BIT_W-1:0] bit_idx, lj_idx, i2s_idx;
    logic [SUB_W-1:0] sub;

    assign bit_idx = BIT_W'(pos / POS_W'(DIV));
    assign sub     = SUB_W'(pos % POS_W'(DIV));
    assign lj_idx  = BIT_W'(PAIR_BITS - 1) - bit_idx;
    assign i2s_idx = lj_idx + 1'b1;

    assign sclk = (sub >= SUB_W'(DIV / 2));
    assign lrck = (bit_idx >= BIT_W'(WORD_BITS));

    always_comb begin
        if (!i2s)
            sdata = pair[lj_idx];
        else if (bit_idx == '0)
            sdata = prev_lsb;
        else
            sdata = pair[i2s_idx];
    end

endmodule

// File: rtl/tdm_pair_extractor.sv
module tdm_pair_extractor
    import tdm_x_pkg::*;
#(
    parameter int FRAME_BITS = 256,
    parameter int SLOTS      = 4,
    parameter int WORD_BITS  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tdm_fs,
    input  logic [ADC_LINES-1:0] adc_sd,
    input  logic                 adc_lrck,
    input  logic                 adc_sclk,
    input  logic [2:0]           pick_sel,
    input  logic                 clk_ext,
    input  logic                 fmt_i2s,
    output logic                 tx_sdata,
    output logic                 tx_lrck,
    output logic                 tx_sclk
);

    localparam int POS_W     = $clog2(FRAME_BITS);
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int PAIR_BITS = 2 * WORD_BITS;

    route_cfg_t           cfg_in, cfg_eff;
    logic [POS_W-1:0]     pos;
    logic                 frame_last;
    logic [PAIR_BITS-1:0] pair;
    logic                 prev_lsb;
    logic                 gen_sdata, gen_lrck, gen_sclk;
    logic                 pass_bit;

    assign cfg_in = '{pick: pick_sel, ext_clk: clk_ext, i2s: fmt_i2s};

    tdm_frame_tracker #(.FRAME_BITS(FRAME_BITS)) u_track (
        .clk        (clk),
        .rst        (rst),
        .fs         (tdm_fs),
        .cfg_in     (cfg_in),
        .pos        (pos),
        .cfg_eff    (cfg_eff),
        .frame_last (frame_last)
    );

    tdm_pair_capture #(
        .FRAME_BITS (FRAME_BITS),
        .SLOTS      (SLOTS),
        .WORD_BITS  (WORD_BITS)
    ) u_cap (
        .clk        (clk),
        .rst        (rst),
        .din        (adc_sd[TDM_LINE]),
        .pos        (pos),
        .slot       (SLOT_W'(cfg_eff.pick[1:0])),
        .enable     (pick_is_slot(cfg_eff.pick)),
        .frame_last (frame_last),
        .pair       (pair),
        .prev_lsb   (prev_lsb)
    );

    stereo_serializer #(
        .FRAME_BITS (FRAME_BITS),
        .WORD_BITS  (WORD_BITS)
    ) u_ser (
        .pos      (pos),
        .pair     (pair),
        .prev_lsb (prev_lsb),
        .i2s      (cfg_eff.i2s),
        .sdata    (gen_sdata),
        .lrck     (gen_lrck),
        .sclk     (gen_sclk)
    );

    assign pass_bit = adc_sd[pick_line(cfg_eff.pick)];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sdata <= 1'b0;
            tx_lrck  <= 1'b0;
            tx_sclk  <= 1'b0;
        end else begin
            tx_sdata <= pick_is_slot(cfg_eff.pick) ? gen_sdata : pass_bit;
            tx_lrck  <= cfg_eff.ext_clk ? gen_lrck : adc_lrck;
            tx_sclk  <= cfg_eff.ext_clk ? gen_sclk : adc_sclk;
        end
    end

    // R9
    adc_clk_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_eff.ext_clk |=> (tx_sclk == $past(adc_sclk) && tx_lrck == $past(adc_lrck)));

    // R8
    tdm_line_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_eff.pick == 3'b011) |=> (tx_sdata == $past(adc_sd[TDM_LINE])));

    // R5
    gen_lrck_left_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_eff.ext_clk && pos == '0) |=> !tx_lrck);

endmodule

// File: tb/tb_tdm_pair_extractor.sv
module tb_tdm_pair_extractor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tdm_fs = 1'b0;
    logic [3:0] adc_sd = '0;
    logic       adc_lrck = 1'b0;
    logic       adc_sclk = 1'b0;
    logic [2:0] pick_sel = 3'b100;
    logic       clk_ext = 1'b1;
    logic       fmt_i2s = 1'b0;
    logic       tx_sdata, tx_lrck, tx_sclk;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;
    int fr       = 0;
    logic [63:0] m_pair = '0;
    logic        m_prev = 1'b0;

    always #2 clk = ~clk;

    tdm_pair_extractor dut (
        .clk(clk), .rst(rst), .tdm_fs(tdm_fs), .adc_sd(adc_sd),
        .adc_lrck(adc_lrck), .adc_sclk(adc_sclk), .pick_sel(pick_sel),
        .clk_ext(clk_ext), .fmt_i2s(fmt_i2s),
        .tx_sdata(tx_sdata), .tx_lrck(tx_lrck), .tx_sclk(tx_sclk)
    );

    // {cfg at frame start, cfg after change, change position (256 = none)}
    // cfg = {route[2:0], clk_ext, fmt_i2s}
    localparam logic [18:0] VECS [16] = '{
        {3'b100, 1'b1, 1'b0, 3'b100, 1'b1, 1'b0, 9'd256},
        {3'b100, 1'b1, 1'b0, 3'b100, 1'b1, 1'b0, 9'd256},
        {3'b101, 1'b1, 1'b0, 3'b101, 1'b1, 1'b0, 9'd256},
        {3'b110, 1'b1, 1'b1, 3'b110, 1'b1, 1'b1, 9'd256},
        {3'b111, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 9'd256},
        {3'b111, 1'b1, 1'b0, 3'b111, 1'b1, 1'b0, 9'd256},
        {3'b000, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0, 9'd256},
        {3'b001, 1'b0, 1'b0, 3'b001, 1'b0, 1'b0, 9'd256},
        {3'b010, 1'b0, 1'b1, 3'b010, 1'b0, 1'b1, 9'd256},
        {3'b011, 1'b1, 1'b0, 3'b011, 1'b1, 1'b0, 9'd256},
        {3'b100, 1'b0, 1'b0, 3'b100, 1'b0, 1'b0, 9'd256},
        {3'b101, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 9'd100},
        {3'b110, 1'b1, 1'b1, 3'b011, 1'b0, 1'b0, 9'd1},
        {3'b000, 1'b0, 1'b0, 3'b111, 1'b1, 1'b1, 9'd255},
        {3'b100, 1'b1, 1'b0, 3'b100, 1'b1, 1'b0, 9'd256},
        {3'b111, 1'b1, 1'b1, 3'b111, 1'b1, 1'b1, 9'd256}
    };

    function automatic logic [63:0] slot_pair(input int f, input int s);
        logic [31:0] l, r;
        l = 32'h8000_0001 ^ (32'h1111_1111 * (s + 1)) ^ (f * 32'h0102_0408);
        r = {l[15:0], l[31:16]} ^ 32'h0F0F_00FF;
        return {l, r};
    endfunction

    function automatic logic line_bit(input int ln, input int p, input int f);
        case (ln)
            0:       return p[0] ^ p[3] ^ f[0];
            2:       return p[1] ^ p[5];
            3:       return ~(p[2] ^ p[6]);
            default: return 1'b0;
        endcase
    endfunction

    // R8 route-code to line mapping
    function automatic int map_line(input logic [2:0] s);
        case (s[1:0])
            2'd0:    return 0;
            2'd1:    return 2;
            2'd2:    return 3;
            default: return 1;
        endcase
    endfunction

    task automatic run_frame(input logic [4:0] c0, input logic [4:0] c1,
                             input int chg, input string tag);
        logic [4:0]  act, cur;
        logic [63:0] tdm;
        logic        e_d, e_l, e_s;
        bit          bad;
        int          b;
        bad = 1'b0;
        act = c0;
        for (int p = 0; p < 256; p++) begin
            cur = (p >= chg) ? c1 : c0;
            if (p == 0) act = cur;
            {pick_sel, clk_ext, fmt_i2s} = cur;
            tdm_fs    = (p == 0);
            tdm       = slot_pair(fr, p / 64);
            adc_sd[1] = tdm[63 - (p % 64)];
            adc_sd[0] = line_bit(0, p, fr);
            adc_sd[2] = line_bit(2, p, fr);
            adc_sd[3] = line_bit(3, p, fr);
            adc_lrck  = p[5];
            adc_sclk  = p[0];
            if (act[1]) begin
                e_s = ((p % 4) >= 2);
                e_l = (p >= 128);
            end else begin
                e_s = adc_sclk;
                e_l = adc_lrck;
            end
            if (act[4]) begin
                b = p / 4;
                if (act[0])
                    e_d = (b == 0) ? m_prev : m_pair[64 - b];
                else
                    e_d = m_pair[63 - b];
            end else begin
                e_d = adc_sd[map_line(act[4:2])];
            end
            @(negedge clk);
            if (!bad && {tx_sdata, tx_lrck, tx_sclk} !== {e_d, e_l, e_s}) begin
                bad = 1'b1;
                $display("FAIL %s frame %0d pos %0d: data/lrck/sclk got %b%b%b expected %b%b%b",
                         tag, fr, p, tx_sdata, tx_lrck, tx_sclk, e_d, e_l, e_s);
            end
        end
        n_checks++;
        if (bad) n_fails++;
        m_prev = m_pair[0];
        if (act[4]) m_pair = slot_pair(fr, int'(act[3:2]));
        fr++;
    endtask

    // R11: outputs cleared in reset; defaults active until first frame start
    task automatic reset_defaults();
        bit bad;
        logic e_s;
        pick_sel = 3'b000; clk_ext = 1'b0; fmt_i2s = 1'b1;
        tdm_fs = 1'b0; adc_sd = 4'b0001; adc_lrck = 1'b1; adc_sclk = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        n_checks++;
        if ({tx_sdata, tx_lrck, tx_sclk} !== 3'b000) begin
            n_fails++;
            $display("FAIL R11 in reset: outputs got %b%b%b expected 000",
                     tx_sdata, tx_lrck, tx_sclk);
        end
        rst = 1'b0;
        m_pair = '0;
        m_prev = 1'b0;
        bad = 1'b0;
        for (int k = 1; k <= 50; k++) begin
            @(negedge clk);
            e_s = ((k % 4) >= 2);
            if (!bad && {tx_sdata, tx_lrck, tx_sclk} !== {1'b0, 1'b0, e_s}) begin
                bad = 1'b1;
                $display("FAIL R11 default setting cycle %0d: got %b%b%b expected 00%b",
                         k, tx_sdata, tx_lrck, tx_sclk, e_s);
            end
        end
        n_checks++;
        if (bad) n_fails++;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R12 watchdog: run active after 200000 cycles, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        string tag;
        logic [4:0] c0, c1;
        int chg;
        @(negedge clk);
        reset_defaults();
        for (int i = 0; i < 16; i++) begin
            c0  = VECS[i][18:14];
            c1  = VECS[i][13:9];
            chg = int'(VECS[i][8:0]);
            if (c0[4])
                tag = c0[0] ? "R1 R2 R3 R4 R5 R7 R12" : "R1 R2 R3 R4 R5 R6 R12";
            else
                tag = "R8 R12";
            if (!c0[1]) tag = {tag, " R9"};
            if (chg < 256) tag = {tag, " R10"};
            run_frame(c0, c1, chg, tag);
        end
        reset_defaults();
        run_frame({3'b100, 1'b1, 1'b0}, {3'b100, 1'b1, 1'b0}, 256, "R11 R3 empty buffer");
        run_frame({3'b101, 1'b1, 1'b1}, {3'b101, 1'b1, 1'b1}, 256, "R11 R7 after reset");
        run_frame({3'b110, 1'b1, 1'b0}, {3'b110, 1'b1, 1'b0}, 256, "R2 R6 after reset");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule